// File: doc/BRIEF.md
# Multi-Rail Supervisor Reset Sequencer

This block is the digital core of a supply supervisor. It merges per-rail undervoltage flags, an active-low pushbutton reset and a watchdog timeout into one active-low system reset. Each cause restarts a reset-timeout counter, and the reset is released only after that counter has run its full length with every cause gone. The block also drives an active-low watchdog output and one active-low fault line per monitored rail. All inputs arrive already synchronized to `clk`.

The pushbutton input is filtered inside the block. Pressing it takes effect at once. Releasing it counts only after the input has stayed high for a set number of cycles, so contact bounce cannot shorten the reset. A supply-valid input acts as an undervoltage lockout. While it is low, every output is held in its defined safe state and all counters restart.

For board-level testing, a margin input forces every output high while the supplies are moved away from nominal. The watchdog keeps counting during margin test. A timeout that occurs in that window is held back and applied as soon as margin test ends.

Top module: `supervisor_seq`

## Requirements
- R1: While `supply_ok` is low, `reset_n` is 0, `wdo_n` is 1 and every `rail_fault_n` bit is 0, whatever `margin_n` is. After `supply_ok` goes high with no other cause present, `reset_n` rises after exactly RST_CYCLES rising clock edges.
- R2: After the block reset `rst_n` is released with supply good and no other cause present, `reset_n` stays low for exactly RST_CYCLES clock edges.
- R3: One clock edge after rail flag `rail_uv[i]` goes to 1 (1 = undervoltage), `reset_n` is 0 and `rail_fault_n[i]` is 0. The fault bits of good rails stay 1.
- R4: Once every rail flag is 0, `reset_n` stays low for exactly RST_CYCLES more edges. Any cause seen during that time restarts the count from zero.
- R5: A 0 on `man_rst_n` drives `reset_n` to 0 one clock edge later.
- R6: After `man_rst_n` returns to 1, `reset_n` rises after exactly DEB_CYCLES + RST_CYCLES edges. A low glitch at any point in the high-debounce window restarts that window.
- R7: When WD_CYCLES edges pass after reset release with no rising edge on `wdi`, `reset_n` and `wdo_n` both go to 0 on the same edge. They both return to 1 after RST_CYCLES edges.
- R8: A rising edge on `wdi` restarts the watchdog count. With rising edges spaced closer than WD_CYCLES apart, `reset_n` never falls.
- R9: While `margin_n` is 0 and `supply_ok` is 1, `reset_n`, `wdo_n` and all `rail_fault_n` bits are 1.
- R10: The watchdog keeps counting during margin test. A timeout that falls in margin test drives `reset_n` and `wdo_n` to 0 on the first clock edge after `margin_n` returns to 1. Both then stay low for RST_CYCLES edges.
- R11: When `margin_n` returns to 1, the outputs show the block's current internal state with no added delay. For example, a rail still in undervoltage shows `reset_n` 0 and its fault bit 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| supply_ok | input | 1 | Supply valid; low means undervoltage lockout |
| rail_uv | input | N_RAILS | Per-rail undervoltage flags, 1 = rail low |
| man_rst_n | input | 1 | Pushbutton reset request, active low |
| wdi | input | 1 | Watchdog service input; a rising edge restarts the count |
| margin_n | input | 1 | Margin test enable, active low |
| reset_n | output | 1 | System reset, active low |
| wdo_n | output | 1 | Watchdog timeout indication, active low |
| rail_fault_n | output | N_RAILS | Per-rail fault indication, active low |

## Verification
Rail, pushbutton and watchdog causes reach `reset_n` and `rail_fault_n` one clock edge after they are sampled. Release comes RST_CYCLES edges after the last cause, or DEB_CYCLES + RST_CYCLES edges for the pushbutton. A watchdog timeout lands WD_CYCLES edges after the last release or service edge. The margin and lockout overrides act combinationally, with no clock edge. The bench changes inputs on the falling edge and samples one half period after each rising edge. For each sequence it counts the rising edges until the output changes and compares that count with the figure derived from the requirement. Override checks are sampled a short delay after the input change, before any clock edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

   // counter width able to hold 0 .. n-1
   function automatic int cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   typedef enum logic [1:0] {
      OUT_LOCKOUT = 2'd0,
      OUT_MARGIN  = 2'd1,
      OUT_NORMAL  = 2'd2
   } out_mode_e;

endpackage

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
   parameter int DEB_CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_n,
   output logic filt_n
);
   generate
      if (DEB_CYCLES < 0) begin : g_bad_deb
         $error("sup_mr_filter: DEB_CYCLES must not be negative");
      end

      if (DEB_CYCLES == 0) begin : g_bypass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) filt_n <= 1'b1;
            else        filt_n <= raw_n;
         end
      end else begin : g_count
         localparam int W = sup_pkg::cnt_w(DEB_CYCLES);
         localparam logic [W-1:0] LAST = W'(DEB_CYCLES - 1);
         logic [W-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_n <= 1'b1;
               cnt    <= '0;
            end else if (!raw_n) begin
               filt_n <= 1'b0;
               cnt    <= '0;
            end else if (!filt_n) begin
               if (cnt == LAST) filt_n <= 1'b1;
               else             cnt    <= cnt + 1'b1;
            end
         end

         // R6: release only once the high run has reached its full length
         a_r6_release_after_run: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(filt_n) |-> $past(cnt) == LAST && $past(raw_n));
      end
   endgenerate

   // R5: a low level is acted on at the next edge
   a_r5_low_passes: assert property (@(posedge clk) disable iff (!rst_n)
      !raw_n |=> !filt_n);

endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
   parameter int RST_CYCLES = 14_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic active,
   output logic done
);
   localparam int W = sup_pkg::cnt_w(RST_CYCLES);
   localparam logic [W-1:0] LAST = W'(RST_CYCLES - 1);

   generate
      if (RST_CYCLES < 2) begin : g_bad_rst
         $error("sup_rst_timer: RST_CYCLES must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   assign done = active && !hold && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (hold) begin
         active <= 1'b1;
         cnt    <= '0;
      end else if (active) begin
         if (cnt == LAST) active <= 1'b0;
         else             cnt    <= cnt + 1'b1;
      end
   end

   // R4: any cause restarts the timeout from zero
   a_r4_hold_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> active && cnt == '0);

   // R4: release only after the full count with no cause present
   a_r4_full_period: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> $past(cnt) == LAST && !$past(hold));

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
   parameter int WD_CYCLES = 160_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic wdi,
   output logic hit
);
   localparam int W = sup_pkg::cnt_w(WD_CYCLES);
   localparam logic [W-1:0] LAST = W'(WD_CYCLES - 1);

   generate
      if (WD_CYCLES < 2) begin : g_bad_wd
         $error("sup_wdog: WD_CYCLES must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;
   logic         wdi_q;
   logic         kick;

   assign kick = wdi && !wdi_q;
   assign hit  = !clr && !kick && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdi_q <= 1'b0;
         cnt   <= '0;
      end else begin
         wdi_q <= wdi;
         if (clr || kick || hit) cnt <= '0;
         else                    cnt <= cnt + 1'b1;
      end
   end

   // R8: a service edge restarts the count
   a_r8_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdi) |=> cnt == '0);

   // R7: a timeout restarts the count
   a_r7_hit_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> cnt == '0);

endmodule

// File: rtl/supervisor_seq.sv
module supervisor_seq #(
   parameter int N_RAILS    = 6,
   parameter int RST_CYCLES = 14_000_000,
   parameter int DEB_CYCLES = 1_000_000,
   parameter int WD_CYCLES  = 160_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               supply_ok,
   input  logic [N_RAILS-1:0] rail_uv,
   input  logic               man_rst_n,
   input  logic               wdi,
   input  logic               margin_n,
   output logic               reset_n,
   output logic               wdo_n,
   output logic [N_RAILS-1:0] rail_fault_n
);
   import sup_pkg::*;

   generate
      if (N_RAILS < 1) begin : g_bad_rails
         $error("supervisor_seq: N_RAILS must be at least 1");
      end
   endgenerate

   logic               mr_filt_n;
   logic               wd_hit;
   logic               active;
   logic               rel;
   logic               pend;
   logic               wd_flag;
   logic [N_RAILS-1:0] rail_q;
   logic               margin_on;
   logic               start_wd;
   logic               hold;
   out_mode_e          mode;

   sup_mr_filter #(.DEB_CYCLES(DEB_CYCLES)) u_mr (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_n  (man_rst_n),
      .filt_n (mr_filt_n)
   );

   assign margin_on = !margin_n;
   assign start_wd  = (wd_hit || pend) && !margin_on;
   assign hold      = !supply_ok || (|rail_uv) || !man_rst_n || !mr_filt_n || start_wd;

   sup_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (hold),
      .active (active),
      .done   (rel)
   );

   sup_wdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!supply_ok || active),
      .wdi   (wdi),
      .hit   (wd_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend    <= 1'b0;
         wd_flag <= 1'b0;
         rail_q  <= '0;
      end else begin
         rail_q <= rail_uv;
         if (!supply_ok) begin
            pend    <= 1'b0;
            wd_flag <= 1'b0;
         end else begin
            if (wd_hit && margin_on) pend <= 1'b1;
            else if (!margin_on)     pend <= 1'b0;
            if (start_wd)            wd_flag <= 1'b1;
            else if (rel)            wd_flag <= 1'b0;
         end
      end
   end

   always_comb begin
      if (!supply_ok)     mode = OUT_LOCKOUT;
      else if (margin_on) mode = OUT_MARGIN;
      else                mode = OUT_NORMAL;
   end

   always_comb begin
      unique case (mode)
         OUT_LOCKOUT: begin
            reset_n      = 1'b0;
            wdo_n        = 1'b1;
            rail_fault_n = '0;
         end
         OUT_MARGIN: begin
            reset_n      = 1'b1;
            wdo_n        = 1'b1;
            rail_fault_n = '1;
         end
         default: begin
            reset_n      = !active;
            wdo_n        = !wd_flag;
            rail_fault_n = ~rail_q;
         end
      endcase
   end

   // R10: a timeout inside margin test is kept for later
   a_r10_defer: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_hit && margin_on && supply_ok) |=> pend);

   // R7: a timeout outside margin test starts a reset with the watchdog flag
   a_r7_wd_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_hit && !margin_on && supply_ok) |=> active && wd_flag);

   // R1: lockout clears the deferred timeout
   a_r1_lockout_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !pend && !wd_flag && active);

   // R3: a low rail is latched for the fault outputs
   a_r3_rail_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (|rail_uv) |=> (|rail_q) && active);

endmodule

// File: tb/tb_supervisor_seq.sv
module tb_supervisor_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NR  = 4;
   localparam int RST = 20;
   localparam int DEB = 4;
   localparam int WD  = 30;

   logic          clk = 1'b0;
   logic          rst_n, supply_ok, man_rst_n, wdi, margin_n;
   logic [NR-1:0] rail_uv;
   logic          reset_n, wdo_n;
   logic [NR-1:0] rail_fault_n;
   logic          kick_en;
   int            checks = 0;
   int            failures = 0;
   bit            finished = 1'b0;

   // table: {rail pattern[4:1], margin_n[0]}
   localparam logic [4:0] VEC [7] = '{
      5'b0001_1, 5'b0100_1, 5'b1010_0, 5'b1111_1,
      5'b1000_0, 5'b0110_1, 5'b0000_0 };

   always #(CLK_PERIOD/2) clk = ~clk;

   supervisor_seq #(.N_RAILS(NR), .RST_CYCLES(RST), .DEB_CYCLES(DEB), .WD_CYCLES(WD)) dut (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .rail_uv(rail_uv),
      .man_rst_n(man_rst_n), .wdi(wdi), .margin_n(margin_n),
      .reset_n(reset_n), .wdo_n(wdo_n), .rail_fault_n(rail_fault_n));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // edges until the chosen output reaches lvl (0 = reset_n, 1 = wdo_n)
   task automatic count_until(input int which, input logic lvl, output int n);
      n = 200;
      for (int i = 1; i <= 200; i++) begin
         tick();
         if (((which == 0) ? reset_n : wdo_n) == lvl) begin
            n = i;
            break;
         end
      end
   endtask

   // background service edges on wdi, one rising edge every 8 cycles
   initial begin
      wdi = 1'b0;
      forever begin
         @(negedge clk);
         if (kick_en) begin
            repeat (3) @(negedge clk);
            wdi = ~wdi;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n;
      int bad;
      rst_n = 1'b0; supply_ok = 1'b0; man_rst_n = 1'b1; margin_n = 1'b0;
      rail_uv = '0; kick_en = 1'b1;
      #1;
      // R1: lockout state beats margin
      chk(reset_n == 1'b0 && wdo_n == 1'b1 && rail_fault_n == '0, "R1 lockout outputs",
          {reset_n, wdo_n, rail_fault_n}, 6'b010000);
      tick(); tick();
      rst_n = 1'b1; margin_n = 1'b1;
      tick(); tick();
      chk(reset_n == 1'b0 && wdo_n == 1'b1 && rail_fault_n == '0, "R1 lockout after rst",
          {reset_n, wdo_n, rail_fault_n}, 6'b010000);
      supply_ok = 1'b1;
      count_until(0, 1'b1, n);
      chk(n == RST, "R1 supply rise to release", n, RST);

      // R2: block reset, supply already good
      rst_n = 1'b0; tick(); rst_n = 1'b1;
      count_until(0, 1'b1, n);
      chk(n == RST, "R2 power-up timeout", n, RST);

      // R3/R9: vector table walk
      for (int i = 0; i < 7; i++) begin
         logic [NR-1:0] pat;
         logic          mg;
         pat = VEC[i][4:1];
         mg  = VEC[i][0];
         rail_uv = pat; margin_n = mg;
         tick();
         if (mg) chk(reset_n == 1'b0 && rail_fault_n == ~pat, "R3 rail table",
                     {reset_n, rail_fault_n}, {1'b0, ~pat});
         else    chk(reset_n && wdo_n && rail_fault_n == '1, "R9 margin table",
                     {reset_n, wdo_n, rail_fault_n}, 6'b111111);
      end
      margin_n = 1'b1; rail_uv = 4'b0001;
      tick();
      rail_uv = '0;
      count_until(0, 1'b1, n);
      chk(n == RST, "R4 rails good to release", n, RST);

      // R5 / R6: pushbutton
      man_rst_n = 1'b0;
      tick();
      chk(reset_n == 1'b0, "R5 pushbutton asserts", reset_n, 0);
      repeat (4) tick();
      man_rst_n = 1'b1;
      count_until(0, 1'b1, n);
      chk(n == DEB + RST, "R6 release delay", n, DEB + RST);

      man_rst_n = 1'b0; repeat (3) tick();
      man_rst_n = 1'b1; repeat (2) tick();
      man_rst_n = 1'b0; tick();
      man_rst_n = 1'b1;
      count_until(0, 1'b1, n);
      chk(n == DEB + RST, "R6 bounce restarts filter", n, DEB + RST);

      // R8: regular service keeps reset high
      bad = 0;
      for (int i = 0; i < 100; i++) begin
         tick();
         if (!reset_n || !wdo_n) bad++;
      end
      chk(bad == 0, "R8 serviced watchdog", bad, 0);

      // R7: timeout with no service
      kick_en = 1'b0;
      rst_n = 1'b0; tick(); rst_n = 1'b1;
      count_until(0, 1'b1, n);
      chk(n == RST, "R2 power-up before watchdog", n, RST);
      count_until(1, 1'b0, n);
      chk(n == WD && reset_n == 1'b0, "R7 timeout edge", n, WD);
      count_until(1, 1'b1, n);
      chk(n == RST && reset_n == 1'b1, "R7 timeout length", n, RST);

      // R10: timeout inside margin test is deferred
      margin_n = 1'b0;
      bad = 0;
      for (int i = 0; i < 50; i++) begin
         tick();
         if (!reset_n || !wdo_n || rail_fault_n != '1) bad++;
      end
      chk(bad == 0, "R9 outputs high during margin", bad, 0);
      margin_n = 1'b1;
      #1;
      chk(reset_n && wdo_n, "R10 nothing before edge", {reset_n, wdo_n}, 2'b11);
      count_until(0, 1'b0, n);
      chk(n == 1 && wdo_n == 1'b0, "R10 deferred timeout", n, 1);
      kick_en = 1'b1;
      count_until(0, 1'b1, n);
      chk(n == RST && wdo_n == 1'b1, "R10 deferred length", n, RST);

      // R11: margin exit shows current state at once
      margin_n = 1'b0; rail_uv = 4'b0010;
      tick(); tick();
      chk(reset_n && rail_fault_n == '1, "R9 margin hides rail", {reset_n, rail_fault_n}, 5'b11111);
      margin_n = 1'b1;
      #1;
      chk(reset_n == 1'b0 && rail_fault_n == 4'b1101, "R11 margin exit",
          {reset_n, rail_fault_n}, 5'b01101);
      tick();
      rail_uv = '0;
      count_until(0, 1'b1, n);
      chk(n == RST, "R4 second release", n, RST);

      // R1: lockout mid-run during margin, then recovery
      repeat (5) tick();
      margin_n = 1'b0; supply_ok = 1'b0;
      #1;
      chk(reset_n == 1'b0 && wdo_n == 1'b1 && rail_fault_n == '0, "R1 lockout over margin",
          {reset_n, wdo_n, rail_fault_n}, 6'b010000);
      tick(); tick();
      margin_n = 1'b1; supply_ok = 1'b1;
      count_until(0, 1'b1, n);
      chk(n == RST, "R1 recovery timeout", n, RST);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule